// File: doc/BRIEF.md
# Error Code Beep Pattern Generator

This block turns an 8-bit fault code into an on/off envelope for a speaker. The code is split into four 2-bit fields. Each field is played as a group of short beeps, with the beep count equal to the field value plus one, so every group has one to four beeps. The most significant field is played first. For example, the code 16h is heard as 1-2-2-3. Short silences separate beeps inside a group, and a longer silence separates one group from the next.

A code enters through a valid/ready handshake. Ready is high only while the block is idle, so a producer facing back-pressure holds valid and the code steady until ready is high. A separate plain request pin plays one short beep, for example as an "all good, about to boot" signal. Both kinds of sequence end with a trailing short gap and then a one-cycle done pulse. The tone frequency and the speaker driver sit outside this block. Only the envelope, tone_en, is produced here.

The beep length, the gap inside a group and the gap between groups are parameters counted in clock cycles.

Top module: `beep_pattern_gen`

## Requirements
- R1: After reset, tone_en, busy and done are low and req_ready is high.
- R2: A code is accepted on a clock edge where req_valid and req_ready are both high. req_ready is high only while the block is idle. Codes presented and single_req pulses raised while a sequence runs are ignored, and the pattern in progress does not change.
- R3: Groups come from code bits [7:6], then [5:4], then [3:2], then [1:0]. Each group has (field value + 1) beeps, so 16h plays 1-2-2-3, 00h plays 1-1-1-1 and FFh plays 4-4-4-4.
- R4: Every beep holds tone_en high for exactly ON_CYC consecutive cycles.
- R5: Consecutive beeps in the same group are separated by exactly GAP_CYC low cycles.
- R6: Consecutive groups are separated by exactly GROUP_GAP_CYC low cycles.
- R7: After the final beep, tone_en stays low for GAP_CYC cycles. done is then high for exactly one cycle. busy is high from the cycle after acceptance through the done cycle, and low in the cycle after it.
- R8: While idle, a single_req with req_valid low plays exactly one beep, followed by the trailing gap and done. If req_valid and single_req are high together, the code is taken and single_req is ignored.
- R9: The first beep starts in the cycle right after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A code is offered |
| req_ready | output | 1 | Block is idle and will take a code |
| req_code | input | 8 | Fault code to play |
| single_req | input | 1 | Play one short beep (honoured only when idle) |
| tone_en | output | 1 | Beep envelope: high while the tone should sound |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |

## Verification
The bench builds the block with ON_CYC=3, GAP_CYC=2 and GROUP_GAP_CYC=5. Because these three lengths differ, a gap used in the wrong place or a beep off by one cycle shows up as a wrong run length. The lengths are also short enough that whole patterns with up to sixteen beeps, back-to-back requests and requests raised during a sequence all fit in a short run. Codes 16h, 00h, FFh and E4h cover the smallest and largest groups and a descending group order.

// File: rtl/beep_pkg.sv
package beep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_BEEP_ON   = 3'd1,
    ST_BEEP_GAP  = 3'd2,
    ST_GROUP_GAP = 3'd3,
    ST_DONE      = 3'd4
  } beep_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/beep_field_mux.sv
module beep_field_mux #(
  parameter int GROUPS  = 4,
  parameter int FIELD_W = 2,
  localparam int CODE_W = GROUPS * FIELD_W,
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic [CODE_W-1:0]  code,
  input  logic [GRP_W-1:0]   sel,
  output logic [FIELD_W-1:0] field
);
  logic [FIELD_W-1:0] fields [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_field
    assign fields[g] = code[g*FIELD_W +: FIELD_W];
  end

  always_comb begin
    field = '0;
    for (int i = 0; i < GROUPS; i++) begin
      if (sel == GRP_W'(i)) field = fields[i];
    end
  end
endmodule

// File: rtl/beep_timer.sv
module beep_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load)     cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R4: a running interval shrinks by one each cycle (sets every beep and gap length)
  assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R4: a load lands exactly
  assert_timer_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/beep_seq_fsm.sv
module beep_seq_fsm
  import beep_pkg::*;
#(
  parameter int GROUPS        = 4,
  parameter int FIELD_W       = 2,
  parameter int ON_CYC        = 3,
  parameter int GAP_CYC       = 2,
  parameter int GROUP_GAP_CYC = 5,
  parameter int CNT_W         = 8,
  localparam int CODE_W = GROUPS * FIELD_W,
  localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [CODE_W-1:0]  req_code,
  input  logic               single_req,
  input  logic               tmr_expired,
  output logic               tmr_load,
  output logic [CNT_W-1:0]   tmr_val,
  output logic [CODE_W-1:0]  code_q,
  output logic [GRP_W-1:0]   grp_q,
  input  logic [FIELD_W-1:0] cur_field,
  output logic               req_ready,
  output logic               tone_en,
  output logic               busy,
  output logic               done
);
  localparam logic [CNT_W-1:0] ON_LD  = CNT_W'(ON_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LD = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] GRP_LD = CNT_W'(GROUP_GAP_CYC - 1);

  beep_state_t        state_q, state_d;
  logic [FIELD_W-1:0] beep_idx_q, beep_idx_d;
  logic [CODE_W-1:0]  code_d;
  logic [GRP_W-1:0]   grp_d;
  logic               final_q, final_d;
  logic               last_in_group;

  assign last_in_group = (beep_idx_q == cur_field);

  always_comb begin
    state_d    = state_q;
    beep_idx_d = beep_idx_q;
    code_d     = code_q;
    grp_d      = grp_q;
    final_d    = final_q;
    tmr_load   = 1'b0;
    tmr_val    = ON_LD;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          code_d     = req_code;
          grp_d      = GRP_W'(GROUPS - 1);
          beep_idx_d = '0;
          final_d    = 1'b0;
          state_d    = ST_BEEP_ON;
          tmr_load   = 1'b1;
          tmr_val    = ON_LD;
        end else if (single_req) begin
          code_d     = '0;
          grp_d      = '0;
          beep_idx_d = '0;
          final_d    = 1'b0;
          state_d    = ST_BEEP_ON;
          tmr_load   = 1'b1;
          tmr_val    = ON_LD;
        end
      end
      ST_BEEP_ON: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          if (!last_in_group) begin
            beep_idx_d = beep_idx_q + 1'b1;
            state_d    = ST_BEEP_GAP;
            tmr_val    = GAP_LD;
          end else if (grp_q != '0) begin
            state_d = ST_GROUP_GAP;
            tmr_val = GRP_LD;
          end else begin
            final_d = 1'b1;
            state_d = ST_BEEP_GAP;
            tmr_val = GAP_LD;
          end
        end
      end
      ST_BEEP_GAP: begin
        if (tmr_expired) begin
          if (final_q) begin
            state_d = ST_DONE;
          end else begin
            state_d  = ST_BEEP_ON;
            tmr_load = 1'b1;
            tmr_val  = ON_LD;
          end
        end
      end
      ST_GROUP_GAP: begin
        if (tmr_expired) begin
          grp_d      = grp_q - 1'b1;
          beep_idx_d = '0;
          state_d    = ST_BEEP_ON;
          tmr_load   = 1'b1;
          tmr_val    = ON_LD;
        end
      end
      ST_DONE: begin
        final_d = 1'b0;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      beep_idx_q <= '0;
      code_q     <= '0;
      grp_q      <= '0;
      final_q    <= 1'b0;
    end else begin
      state_q    <= state_d;
      beep_idx_q <= beep_idx_d;
      code_q     <= code_d;
      grp_q      <= grp_d;
      final_q    <= final_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign tone_en   = (state_q == ST_BEEP_ON);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);

  // R7: done lasts one cycle and is followed by idle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R7: busy holds until the done cycle
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R2: a running sequence never offers ready
  assert_no_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R6: a group gap is only taken while groups remain
  assert_group_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GROUP_GAP) |-> (grp_q != '0));

  // R3: beep index never passes the current field value
  assert_beep_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tone_en |-> (beep_idx_q <= cur_field));
endmodule

// File: rtl/beep_pattern_gen.sv
module beep_pattern_gen
  import beep_pkg::*;
#(
  parameter int GROUPS        = 4,
  parameter int FIELD_W       = 2,
  parameter int ON_CYC        = 20000,
  parameter int GAP_CYC       = 20000,
  parameter int GROUP_GAP_CYC = 60000,
  localparam int CODE_W = GROUPS * FIELD_W,
  localparam int MAX_D  = max3(ON_CYC, GAP_CYC, GROUP_GAP_CYC),
  localparam int CNT_W  = (MAX_D > 1) ? $clog2(MAX_D) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CODE_W-1:0] req_code,
  input  logic              single_req,
  output logic              tone_en,
  output logic              busy,
  output logic              done
);
  localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  logic               tmr_load, tmr_expired;
  logic [CNT_W-1:0]   tmr_val;
  logic [CODE_W-1:0]  code_q;
  logic [GRP_W-1:0]   grp_q;
  logic [FIELD_W-1:0] cur_field;

  beep_field_mux #(.GROUPS(GROUPS), .FIELD_W(FIELD_W)) u_mux (
    .code (code_q),
    .sel  (grp_q),
    .field(cur_field)
  );

  beep_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  beep_seq_fsm #(
    .GROUPS(GROUPS), .FIELD_W(FIELD_W), .ON_CYC(ON_CYC), .GAP_CYC(GAP_CYC),
    .GROUP_GAP_CYC(GROUP_GAP_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_code   (req_code),
    .single_req (single_req),
    .tmr_expired(tmr_expired),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .code_q     (code_q),
    .grp_q      (grp_q),
    .cur_field  (cur_field),
    .req_ready  (req_ready),
    .tone_en    (tone_en),
    .busy       (busy),
    .done       (done)
  );

  // R9: first beep right after acceptance
  assert_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (tone_en && busy));

  // R7: the envelope never sounds outside a sequence
  assert_tone_in_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tone_en |-> (busy && !done));
endmodule

// File: tb/tb_beep_pattern_gen.sv
module tb_beep_pattern_gen;
  localparam int ON  = 3;
  localparam int GAP = 2;
  localparam int GG  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_code = 8'h00;
  logic single_req = 1'b0;
  logic req_ready, tone_en, busy, done;

  int checks = 0;
  int failures = 0;

  int    exp_lvl[$];
  int    exp_len[$];
  string exp_tag[$];

  always #2.5 clk = ~clk;

  beep_pattern_gen #(.ON_CYC(ON), .GAP_CYC(GAP), .GROUP_GAP_CYC(GG)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_code(req_code), .single_req(single_req), .tone_en(tone_en),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int lvl, input int len, input string tag);
    exp_lvl.push_back(lvl);
    exp_len.push_back(len);
    exp_tag.push_back(tag);
  endtask

  // expected segments: level 1 = beep, 0 = silence, 2 = done marker
  task automatic push_pattern(input logic [7:0] code, input bit single);
    int ng;
    ng = single ? 1 : 4;
    for (int g = ng - 1; g >= 0; g--) begin
      int n;
      n = single ? 1 : int'(code[g*2 +: 2]) + 1;
      for (int b = 0; b < n; b++) begin
        push(1, ON, "R4/R3 beep length");
        if (b < n - 1) push(0, GAP, "R5 beep gap");
      end
      if (g > 0) push(0, GG, "R6 group gap");
      else       push(0, GAP, "R7 trailing gap");
    end
    push(2, 0, "R7 done pulse");
  endtask

  task automatic emit(input int lvl, input int len);
    if (exp_lvl.size() == 0) begin
      check(1'b0, "R3 unexpected segment", lvl, -1);
    end else begin
      int el, en;
      string t;
      el = exp_lvl.pop_front();
      en = exp_len.pop_front();
      t  = exp_tag.pop_front();
      check(el == lvl && en == len, t, lvl * 1000 + len, el * 1000 + en);
    end
  endtask

  // monitor
  int cur_lvl = 1;
  int run_len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (run_len > 0) emit(cur_lvl, run_len);
        emit(2, 0);
        check(busy == 1'b1, "R7 busy during done", busy, 1);
        run_len = 0;
        cur_lvl = 1;
      end else if (busy) begin
        if (int'(tone_en) == cur_lvl) run_len++;
        else begin
          if (run_len > 0) emit(cur_lvl, run_len);
          cur_lvl = int'(tone_en);
          run_len = 1;
        end
      end
    end
  end

  task automatic send_code(input logic [7:0] code);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    push_pattern(code, 1'b0);
    req_valid = 1'b1;
    req_code  = code;
    @(negedge clk);
    req_valid = 1'b0;
    check(tone_en == 1'b1, "R9 first beep after accept", tone_en, 1);
  endtask

  task automatic send_single();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    push_pattern(8'h00, 1'b1);
    single_req = 1'b1;
    @(negedge clk);
    single_req = 1'b0;
    check(tone_en == 1'b1, "R8 single beep starts", tone_en, 1);
  endtask

  task automatic wait_done_then_idle();
    @(negedge clk);
    while (!done) @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R7 busy low after done", busy, 0);
    check(req_ready == 1'b1, "R2 ready after done", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tone_en == 1'b0, "R1 tone_en in reset", tone_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tone_en == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 outputs idle",
          {tone_en, busy, done}, 0);
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

    send_code(8'h16);
    wait_done_then_idle();
    send_code(8'h00);
    wait_done_then_idle();
    send_code(8'hFF);
    wait_done_then_idle();
    send_single();
    wait_done_then_idle();

    // R8: code and single together -> code wins
    @(negedge clk);
    push_pattern(8'hE4, 1'b0);
    req_valid = 1'b1; req_code = 8'hE4; single_req = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; single_req = 1'b0;
    wait_done_then_idle();

    // R2: requests during a sequence are ignored
    send_code(8'h16);
    repeat (6) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      check(req_ready == 1'b0, "R2 ready low while busy", req_ready, 0);
      req_valid = 1'b1; req_code = 8'hFF; single_req = 1'b1;
      @(negedge clk);
    end
    req_valid = 1'b0; single_req = 1'b0;
    wait_done_then_idle();

    // back-to-back: valid held across the end of a sequence
    push_pattern(8'h1B, 1'b0);
    req_valid = 1'b1; req_code = 8'h1B;
    @(negedge clk);
    push_pattern(8'h40, 1'b0);
    req_code = 8'h40;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done_then_idle();

    repeat (4) @(negedge clk);
    check(exp_lvl.size() == 0, "R3 all expected segments seen", exp_lvl.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule